// File: doc/BRIEF.md
# Bulk-In Packet Release Controller

This block decides how a device answers each bulk-in request from the host on the receive path of a serial bridge. It watches the fill level of the receive FIFO and the time since the last character arrived. From these it answers each request with either an acknowledge plus a byte count, or a NAK. A full packet goes out as soon as enough data is buffered. A partial packet is held back until the line has been quiet for more than a set number of character times, so that short bursts are gathered into fewer transfers.

A low-latency control bit removes that wait: any buffered data is released on the next request. Time is measured in character-time ticks supplied from outside. The controller therefore works at any baud rate the surrounding logic sets up. Packet encoding and the FIFO storage sit outside this block.

Top module: `bulkin_release`

## Requirements
- R1: When `fifo_level` is at least MAX_PKT (64), a request is answered with `resp_ack`=1 and `resp_len`=64.
- R2: When `fifo_level` is between 1 and 63, `low_lat`=0, and at most 3 `char_tick` pulses have been seen since the last `char_rx`, a request is answered with `resp_ack`=0 and `resp_len`=0.
- R3: When `fifo_level` is between 1 and 63, `low_lat`=0, and 4 or more `char_tick` pulses have been seen since the last `char_rx`, a request is answered with `resp_ack`=1 and `resp_len` equal to `fifo_level`.
- R4: When `low_lat`=1 and `fifo_level` is between 1 and 63, a request is answered with `resp_ack`=1 and `resp_len`=`fifo_level`, whatever the idle time.
- R5: When `fifo_level`=0, a request is always answered with `resp_ack`=0 and `resp_len`=0, in both modes and at any idle time.
- R6: The answer appears on `resp_valid`/`resp_ack`/`resp_len` exactly one cycle after `req`. In all other cycles, and after reset, these three outputs are 0. A NAK always carries `resp_len`=0.
- R7: `char_rx` clears the idle count. If `char_rx` and `char_tick` arrive in the same cycle, the clear wins.
- R8: Reset clears the idle count to zero, so a partial-level request made straight after reset in normal mode is NAKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | LVL_W (9) | Bytes currently held in the receive FIFO |
| char_rx | input | 1 | One-cycle strobe per received character |
| char_tick | input | 1 | One-cycle strobe once per character time |
| low_lat | input | 1 | 1 = release any buffered data at once |
| req | input | 1 | One-cycle strobe: a bulk-in request has arrived |
| resp_valid | output | 1 | The answer is present this cycle |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |
| resp_len | output | LEN_W (7) | Bytes to send, capped at MAX_PKT |

## Verification
The bench sweeps FIFO levels around the boundaries: empty, one byte, mid-range, 63, 64, 65 and far above the packet size. Each level is crossed with both modes and with idle counts from 0 to 5 ticks. The empty and 63/64 levels separate the NAK, partial-release and full-packet paths. The 3 and 4 tick counts pin the idle threshold to "more than three". A coincident receive strobe and tick checks that the clear takes priority. A request issued right after reset confirms the reset value of the idle count.

// File: rtl/bulkin_pkg.sv
package bulkin_pkg;
  typedef enum logic {
    RESP_NAK = 1'b0,
    RESP_ACK = 1'b1
  } resp_e;

  typedef struct packed {
    resp_e      kind;
    logic [6:0] len;
  } resp_t;
endpackage

// File: rtl/bulkin_idle_timer.sv
module bulkin_idle_timer #(
  parameter int IDLE_CHARS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic char_rx,
  input  logic char_tick,
  output logic idle
);
  localparam int SAT   = IDLE_CHARS + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (char_rx) begin
      cnt_q <= '0;
    end else if (char_tick && (cnt_q < CNT_W'(SAT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle = (cnt_q >= CNT_W'(SAT));
endmodule

// File: rtl/bulkin_decider.sv
module bulkin_decider
  import bulkin_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int LVL_W   = 9,
  parameter int LEN_W   = 7
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             idle,
  input  logic             low_lat,
  output resp_e            kind,
  output logic [LEN_W-1:0] len
);
  logic full, empty;

  assign full  = (fifo_level >= LVL_W'(MAX_PKT));
  assign empty = (fifo_level == '0);

  always_comb begin
    kind = RESP_NAK;
    len  = '0;
    if (full) begin
      kind = RESP_ACK;
      len  = LEN_W'(MAX_PKT);
    end else if (!empty && (low_lat || idle)) begin
      kind = RESP_ACK;
      len  = LEN_W'(fifo_level);
    end
  end
endmodule

// File: rtl/bulkin_release.sv
module bulkin_release
  import bulkin_pkg::*;
#(
  parameter int MAX_PKT    = 64,
  parameter int FIFO_DEPTH = 256,
  parameter int IDLE_CHARS = 3,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W     = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             char_rx,
  input  logic             char_tick,
  input  logic             low_lat,
  input  logic             req,
  output logic             resp_valid,
  output logic             resp_ack,
  output logic [LEN_W-1:0] resp_len
);
  logic             idle;
  resp_e            kind;
  logic [LEN_W-1:0] len;

  bulkin_idle_timer #(.IDLE_CHARS(IDLE_CHARS)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .char_rx  (char_rx),
    .char_tick(char_tick),
    .idle     (idle)
  );

  bulkin_decider #(.MAX_PKT(MAX_PKT), .LVL_W(LVL_W), .LEN_W(LEN_W)) dec_i (
    .fifo_level(fifo_level),
    .idle      (idle),
    .low_lat   (low_lat),
    .kind      (kind),
    .len       (len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      resp_len   <= '0;
    end else begin
      resp_valid <= req;
      resp_ack   <= req && (kind == RESP_ACK);
      resp_len   <= req ? len : '0;
    end
  end
endmodule

// File: rtl/bulkin_release_chk.sv
module bulkin_release_chk #(
  parameter int MAX_PKT = 64,
  parameter int LVL_W   = 9,
  parameter int LEN_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] fifo_level,
  input logic             low_lat,
  input logic             req,
  input logic             resp_valid,
  input logic             resp_ack,
  input logic [LEN_W-1:0] resp_len
);
  p_full_ack_r1: assert property (@(posedge clk) disable iff (rst)
    (req && fifo_level >= LVL_W'(MAX_PKT)) |=> (resp_ack && resp_len == LEN_W'(MAX_PKT)));

  p_lowlat_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (req && low_lat && fifo_level != '0 && fifo_level < LVL_W'(MAX_PKT))
      |=> (resp_ack && resp_len == $past(fifo_level[LEN_W-1:0])));

  p_empty_nak_r5: assert property (@(posedge clk) disable iff (rst)
    (req && fifo_level == '0) |=> (resp_valid && !resp_ack));

  p_valid_follows_req_r6: assert property (@(posedge clk) disable iff (rst)
    req |=> resp_valid);

  p_quiet_without_req_r6: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!resp_valid && !resp_ack && resp_len == '0));

  p_nak_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
    !resp_ack |-> (resp_len == '0));

  p_len_cap_r1: assert property (@(posedge clk) disable iff (rst)
    resp_len <= LEN_W'(MAX_PKT));
endmodule

bind bulkin_release bulkin_release_chk #(
  .MAX_PKT(MAX_PKT), .LVL_W(LVL_W), .LEN_W(LEN_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .fifo_level(fifo_level),
  .low_lat   (low_lat),
  .req       (req),
  .resp_valid(resp_valid),
  .resp_ack  (resp_ack),
  .resp_len  (resp_len)
);

// File: tb/bulkin_release_tb.sv
`timescale 1ns/1ps
module bulkin_release_tb_top;
  localparam int MAX_PKT = 64;
  localparam int LVL_W   = 9;
  localparam int LEN_W   = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] fifo_level = '0;
  logic             char_rx = 1'b0;
  logic             char_tick = 1'b0;
  logic             low_lat = 1'b0;
  logic             req = 1'b0;
  logic             resp_valid, resp_ack;
  logic [LEN_W-1:0] resp_len;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bulkin_release dut_i (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .char_rx(char_rx),
    .char_tick(char_tick), .low_lat(low_lat), .req(req),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_len(resp_len)
  );

  task automatic check(string tag, logic v, logic a, logic [LEN_W-1:0] l,
                       logic ev, logic ea, logic [LEN_W-1:0] el);
    checks++;
    if (v !== ev || a !== ea || l !== el) begin
      errors++;
      $display("FAIL %s: got valid=%0b ack=%0b len=%0d, expected valid=%0b ack=%0b len=%0d",
               tag, v, a, l, ev, ea, el);
    end
  endtask

  task automatic pulse_rx();
    char_rx = 1'b1; @(negedge clk); char_rx = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1; @(negedge clk); char_tick = 1'b0; @(negedge clk);
    end
  endtask

  // Issue one request at a negedge; response is registered at the next
  // posedge and sampled at the following negedge.
  task automatic ask(string tag, int lvl, logic ll, logic ea, int el);
    fifo_level = LVL_W'(lvl);
    low_lat = ll;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(tag, resp_valid, resp_ack, resp_len, 1'b1, ea, LEN_W'(el));
    @(negedge clk);
    check({tag, " R6 idle-after"}, resp_valid, resp_ack, resp_len, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset state", resp_valid, resp_ack, resp_len, 1'b0, 1'b0, '0);
    rst = 1'b0;
    @(negedge clk);
    // R8: idle count is zero after reset
    ask("R8 partial after reset", 10, 1'b0, 1'b0, 0);

    // Main sweep: R1..R5
    foreach (lvl_set[li]) begin
      for (int ll = 0; ll < 2; ll++) begin
        for (int k = 0; k <= 5; k++) begin
          int lvl;
          logic ea;
          int el;
          string tag;
          lvl = lvl_set[li];
          pulse_rx();
          ticks(k);
          if (lvl >= MAX_PKT) begin ea = 1'b1; el = MAX_PKT; tag = "R1"; end
          else if (lvl == 0) begin ea = 1'b0; el = 0; tag = "R5"; end
          else if (ll == 1) begin ea = 1'b1; el = lvl; tag = "R4"; end
          else if (k > 3) begin ea = 1'b1; el = lvl; tag = "R3"; end
          else begin ea = 1'b0; el = 0; tag = "R2"; end
          ask($sformatf("%s lvl=%0d ll=%0d ticks=%0d", tag, lvl, ll, k),
              lvl, logic'(ll), ea, el);
        end
      end
    end

    // R7: clear beats a coincident tick
    pulse_rx();
    ticks(5);
    char_rx = 1'b1; char_tick = 1'b1; @(negedge clk);
    char_rx = 1'b0; char_tick = 1'b0; @(negedge clk);
    ticks(3);
    ask("R7 clear wins, 3 ticks after", 20, 1'b0, 1'b0, 0);
    ticks(1);
    ask("R7 fourth tick releases", 20, 1'b0, 1'b1, 20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int lvl_set[9] = '{0, 1, 2, 31, 63, 64, 65, 200, 256};

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule